// File: doc/BRIEF.md
# Half-Single Float Format Converter

The unit converts floating-point values between the 32-bit single format and the 16-bit half format. An opcode chooses the direction. Narrowing (single to half) rounds by a 2-bit mode that comes from outside the block. Widening (half to single) is exact, so it needs no rounding. Subnormal values are handled in full in both directions: narrowing produces half subnormals, and widening normalizes them into single-format normals.

The interface is a valid, an opcode and a 32-bit operand on the input side. The output is a valid and a 32-bit result, both registered one cycle after the input. A narrowed result occupies the low 16 bits and its upper 16 bits are zero. If the narrowed magnitude is still too large for half format after rounding, the result is an infinity carrying the input's sign. This holds in every rounding mode, so the unit never saturates to the largest finite value.

Top module: `fpcvt_half_single`

## Requirements
- R1: Opcode 10 (decimal) narrows the single operand to half. The half value is in result bits [15:0] and result bits [31:16] are zero.
- R2: Rounding mode encoding for narrowing: 0 = nearest, ties to even; 1 = toward +infinity; 2 = toward -infinity; 3 = toward zero. Exactly representable values are never altered.
- R3: If the rounded narrowed magnitude exceeds 65504, the result is 0x7C00 (positive input) or 0xFC00 (negative input), whatever the rounding mode.
- R4: Narrowed magnitudes below 2^-14 become half subnormals (exponent field 0), rounded per R2. This includes single subnormals, which give zero or the smallest subnormal depending on mode and sign.
- R5: Special values. A NaN input gives a quiet NaN of the same sign: 0x7E00/0xFE00 for a narrowed result, 0x7FC00000/0xFFC00000 for a widened one. An infinity maps to the infinity of the same sign. A zero keeps its sign.
- R6: Opcode 11 widens the half value in operand bits [15:0] to the exactly equal single value. Operand bits [31:16] have no effect.
- R7: A half subnormal input to widening gives the normalized single value of equal magnitude.
- R8: out_valid_o equals in_valid_i of the previous cycle, and a result becomes visible one cycle after its valid input.
- R9: A valid input with any other opcode gives a result of zero with out_valid_o set.
- R10: After reset, out_valid_o and result_o are 0. result_o holds its last value during cycles without a valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand and opcode are valid this cycle |
| opcode_i | input | 10 | Operation select: 10 narrow, 11 widen |
| operand_i | input | 32 | Source operand |
| rmode_i | input | 2 | Rounding mode used for narrowing |
| out_valid_o | output | 1 | Result valid, one cycle after the input |
| result_o | output | 32 | Converted value |

## Verification
The only state in the unit is the output register and its valid flag. A fault in that state shows on the very next cycle: a missing or doubled valid, a stale value after an idle gap, or a result paired with the wrong operand. A fault in the datapath shows only for some operands, so the stimulus mixes random operands across all four rounding modes with the cases that hit each edge. Those edges are ties, carries from the mantissa into the exponent, the boundary between subnormal and normal, the overflow threshold, NaNs and signed zeros. This way a wrong rounding increment or a wrong shift count shows up as a mismatched result in the cycle that follows its input.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  localparam int unsigned SP_W   = 32;
  localparam int unsigned SP_EW  = 8;
  localparam int unsigned SP_MW  = 23;
  localparam int unsigned HP_W   = 16;
  localparam int unsigned HP_EW  = 5;
  localparam int unsigned HP_MW  = 10;
  localparam int unsigned SP_BIAS = 127;
  localparam int unsigned HP_BIAS = 15;
  localparam int unsigned BIAS_D  = SP_BIAS - HP_BIAS;          // 112
  localparam int unsigned DROP_W  = SP_MW - HP_MW;              // 13
  localparam int unsigned LZ_W    = $clog2(HP_MW + 1);

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_UP        = 2'd1,
    RM_DOWN      = 2'd2,
    RM_ZERO      = 2'd3
  } rmode_e;

  // leading zeros of a half mantissa
  function automatic logic [LZ_W-1:0] lzc_hm(input logic [HP_MW-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = HP_MW - 1; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      else if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fpcvt_narrow.sv
module fpcvt_narrow
  import fpcvt_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  input  logic [1:0]      rmode_i,
  output logic [HP_W-1:0] hp_o
);
  localparam int unsigned SIG_W   = SP_MW + 1;
  localparam int unsigned PAD_W   = 40;
  localparam int unsigned X_W     = SIG_W + PAD_W;
  localparam int unsigned KEEP_LO = X_W - HP_MW - 1;
  localparam int unsigned SH_MAX  = 31;
  localparam int unsigned SUB_EXP = BIAS_D + 1;                  // 113
  localparam int unsigned OVF_EXP = BIAS_D + (1 << HP_EW) - 1;   // 143

  logic              sgn;
  logic [SP_EW-1:0]  exp;
  logic [SP_MW-1:0]  man;
  logic [SIG_W-1:0]  sig;
  logic [5:0]        sh;
  logic [X_W-1:0]    x;
  logic [HP_MW:0]    keep;
  logic              guard, sticky, inc;
  logic [HP_EW-1:0]  hexp;
  logic [HP_W-1:0]   sum;

  assign sgn = sp_i[SP_W-1];
  assign exp = sp_i[SP_W-2 -: SP_EW];
  assign man = sp_i[SP_MW-1:0];
  assign sig = {|exp, man};

  always_comb begin
    if (exp >= SP_EW'(SUB_EXP)) sh = '0;
    else if ((SUB_EXP - 32'(exp)) > SH_MAX) sh = 6'(SH_MAX);
    else sh = 6'(SUB_EXP - 32'(exp));
  end

  // align so the kept half significand sits at the top
  assign x      = {sig, {PAD_W{1'b0}}} >> sh;
  assign keep   = x[X_W-1 -: HP_MW+1];
  assign guard  = x[KEEP_LO-1];
  assign sticky = |x[KEEP_LO-2:0];

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR_EVEN: inc = guard & (sticky | keep[0]);
      RM_UP:        inc = ~sgn & (guard | sticky);
      RM_DOWN:      inc = sgn & (guard | sticky);
      default:      inc = 1'b0;
    endcase
  end

  assign hexp = (sh == '0) ? HP_EW'(exp - SP_EW'(BIAS_D)) : '0;
  // mantissa carry ripples into the exponent; 0x7C00 is infinity
  assign sum  = {1'b0, hexp, keep[HP_MW-1:0]} + HP_W'(inc);

  always_comb begin
    if (exp == '1)
      hp_o = (man != '0) ? {sgn, {HP_EW{1'b1}}, 1'b1, {(HP_MW-1){1'b0}}}
                         : {sgn, {HP_EW{1'b1}}, {HP_MW{1'b0}}};
    else if (exp >= SP_EW'(OVF_EXP))
      hp_o = {sgn, {HP_EW{1'b1}}, {HP_MW{1'b0}}};
    else
      hp_o = {sgn, sum[HP_W-2:0]};
  end
endmodule

// File: rtl/fpcvt_widen.sv
module fpcvt_widen
  import fpcvt_pkg::*;
(
  input  logic [HP_W-1:0] hp_i,
  output logic [SP_W-1:0] sp_o
);
  logic             sgn;
  logic [HP_EW-1:0] exp;
  logic [HP_MW-1:0] man;
  logic [LZ_W-1:0]  lz;
  logic [HP_MW-1:0] nman;
  logic [SP_EW-1:0] nexp;

  assign sgn  = hp_i[HP_W-1];
  assign exp  = hp_i[HP_W-2 -: HP_EW];
  assign man  = hp_i[HP_MW-1:0];
  assign lz   = lzc_hm(man);
  // shift leading one out as the hidden bit
  assign nman = man << (lz + LZ_W'(1));
  assign nexp = SP_EW'(BIAS_D) - SP_EW'(lz);

  always_comb begin
    if (exp == '1)
      sp_o = (man != '0) ? {sgn, {SP_EW{1'b1}}, 1'b1, {(SP_MW-1){1'b0}}}
                         : {sgn, {SP_EW{1'b1}}, {SP_MW{1'b0}}};
    else if (exp == '0)
      sp_o = (man == '0) ? {sgn, {(SP_W-1){1'b0}}}
                         : {sgn, nexp, nman, {DROP_W{1'b0}}};
    else
      sp_o = {sgn, SP_EW'(exp) + SP_EW'(BIAS_D), man, {DROP_W{1'b0}}};
  end
endmodule

// File: rtl/fpcvt_half_single.sv
module fpcvt_half_single
  import fpcvt_pkg::*;
#(
  parameter int unsigned OPC_W      = 10,
  parameter int unsigned OPC_NARROW = 10,
  parameter int unsigned OPC_WIDEN  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [SP_W-1:0]  operand_i,
  input  logic [1:0]       rmode_i,
  output logic             out_valid_o,
  output logic [SP_W-1:0]  result_o
);
  logic [HP_W-1:0] nar_w;
  logic [SP_W-1:0] wid_w;
  logic [SP_W-1:0] next_w;
  logic            valid_q;
  logic [SP_W-1:0] res_q;

  fpcvt_narrow u_narrow (
    .sp_i    (operand_i),
    .rmode_i (rmode_i),
    .hp_o    (nar_w)
  );

  fpcvt_widen u_widen (
    .hp_i (operand_i[HP_W-1:0]),
    .sp_o (wid_w)
  );

  always_comb begin
    if (opcode_i == OPC_W'(OPC_NARROW))     next_w = {{(SP_W-HP_W){1'b0}}, nar_w};
    else if (opcode_i == OPC_W'(OPC_WIDEN)) next_w = wid_w;
    else                                    next_w = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) res_q <= next_w;
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o) else $error("valid lost"); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o) else $error("spurious valid"); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o)) else $error("result moved"); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == OPC_W'(OPC_NARROW)) |=> result_o[SP_W-1:HP_W] == '0)
    else $error("upper bits set"); // R1
  AST_NARROW_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == OPC_W'(OPC_NARROW)) |=> result_o[HP_W-1] == $past(operand_i[SP_W-1]))
    else $error("narrow sign"); // R5
  AST_WIDEN_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == OPC_W'(OPC_WIDEN)) |=> result_o[SP_W-1] == $past(operand_i[HP_W-1]))
    else $error("widen sign"); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == OPC_W'(OPC_NARROW) && operand_i[SP_W-2 -: SP_EW] != '1
      && operand_i[SP_W-2 -: SP_EW] >= 8'd143)
    |=> result_o[HP_W-2:0] == 15'h7C00) else $error("overflow not inf"); // R3
  AST_OTHER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i != OPC_W'(OPC_NARROW) && opcode_i != OPC_W'(OPC_WIDEN))
    |=> result_o == '0) else $error("other opcode"); // R9
endmodule

// File: tb/fpcvt_half_single_tb.sv
module fpcvt_half_single_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [9:0]  opcode_i = '0;
  logic [31:0] operand_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        out_valid_o;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpcvt_half_single dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .rmode_i(rmode_i), .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [15:0] ref_narrow(input logic [31:0] a, input logic [1:0] rm);
    logic s; int e; longint mm, q; int p, ee, big_e, t, sh, ef; bit hb, st, inc;
    s = a[31]; e = int'(a[30:23]); mm = longint'(a[22:0]);
    if (e == 255) return (mm != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
    ee = (e == 0) ? 1 : e;
    if (e != 0) mm = mm + (64'd1 << 23);
    if (mm == 0) return {s, 15'h0};
    p = 0;
    for (int i = 0; i < 24; i++) if (mm[i]) p = i;
    big_e = p + ee - 150;
    t = (big_e < -14) ? -24 : big_e - 10;
    sh = t - (ee - 150);
    if (sh > 24) begin q = 0; hb = 0; st = 1; end
    else begin
      q  = mm >> sh;
      hb = mm[sh-1];
      st = (mm & ((64'd1 << (sh - 1)) - 1)) != 0;
    end
    case (rm)
      2'd0: inc = hb && (st || q[0]);
      2'd1: inc = !s && (hb || st);
      2'd2: inc = s && (hb || st);
      default: inc = 0;
    endcase
    q = q + longint'(inc);
    if (q == 2048) begin q = 1024; t = t + 1; end
    if (q >= 1024) begin
      ef = t + 25;
      if (ef >= 31) return {s, 15'h7C00};
      return {s, ef[4:0], q[9:0]};
    end
    return {s, 5'd0, q[9:0]};
  endfunction

  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic s; int e, p, ef; logic [22:0] fr; logic [31:0] tmp;
    s = h[15]; e = int'(h[14:10]);
    if (e == 31) return (h[9:0] != 0) ? {s, 31'h7FC00000} : {s, 31'h7F800000};
    if (e == 0) begin
      if (h[9:0] == 0) return {s, 31'h0};
      p = 0;
      for (int i = 0; i < 10; i++) if (h[i]) p = i;
      ef = p - 24 + 127;
      tmp = 32'(h[9:0]) << (23 - p);
      fr = tmp[22:0];
      return {s, ef[7:0], fr};
    end
    ef = e - 15 + 127;
    return {s, ef[7:0], h[9:0], 13'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic run_op(input string req, input logic [9:0] op, input logic [31:0] a,
                        input logic [1:0] rm);
    logic [31:0] exp;
    if (op == 10'd10) exp = {16'h0, ref_narrow(a, rm)};
    else if (op == 10'd11) exp = ref_widen(a[15:0]);
    else exp = '0;
    in_valid_i = 1'b1; opcode_i = op; operand_i = a; rmode_i = rm;
    @(negedge clk);
    in_valid_i = 1'b0;
    chk("R8 valid", {31'h0, out_valid_o}, 32'h1);
    chk(req, result_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'h0, out_valid_o}, 32'h0);
    chk("R10 reset result", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    run_op("R1 one", 10'd10, 32'h3F800000, 2'd0);
    run_op("R1 max finite", 10'd10, 32'h477FE000, 2'd0);
    run_op("R3 tie overflow rne", 10'd10, 32'h477FF000, 2'd0);
    run_op("R3 65520 rtz", 10'd10, 32'h477FF000, 2'd3);
    run_op("R3 big rtz", 10'd10, 32'h49742400, 2'd3);
    run_op("R3 neg big rtz", 10'd10, 32'hC9742400, 2'd3);
    run_op("R3 neg big up", 10'd10, 32'hC9742400, 2'd1);
    run_op("R2 tie rne", 10'd10, 32'h3F801000, 2'd0);
    run_op("R2 tie up", 10'd10, 32'h3F801000, 2'd1);
    run_op("R2 tie zero", 10'd10, 32'h3F801000, 2'd3);
    run_op("R2 neg down", 10'd10, 32'hBF801000, 2'd2);
    run_op("R2 neg up", 10'd10, 32'hBF801000, 2'd1);
    run_op("R2 odd tie rne", 10'd10, 32'h3F803000, 2'd0);
    run_op("R4 min sub", 10'd10, 32'h33800000, 2'd0);
    run_op("R4 half min rne", 10'd10, 32'h33000000, 2'd0);
    run_op("R4 half min up", 10'd10, 32'h33000000, 2'd1);
    run_op("R4 sp sub up", 10'd10, 32'h00000001, 2'd1);
    run_op("R4 sp sub down", 10'd10, 32'h00000001, 2'd2);
    run_op("R4 neg sp sub down", 10'd10, 32'h80000001, 2'd2);
    run_op("R4 2^-15", 10'd10, 32'h38000000, 2'd0);
    run_op("R4 sub to normal carry", 10'd10, 32'h387FF000, 2'd0);
    run_op("R5 nan", 10'd10, 32'h7FC00001, 2'd0);
    run_op("R5 neg snan", 10'd10, 32'hFF800001, 2'd3);
    run_op("R5 neg inf", 10'd10, 32'hFF800000, 2'd0);
    run_op("R5 neg zero", 10'd10, 32'h80000000, 2'd1);
    run_op("R6 one", 10'd11, 32'h00003C00, 2'd0);
    run_op("R6 upper ignored", 10'd11, 32'hABCD3C00, 2'd2);
    run_op("R7 min sub", 10'd11, 32'h00000001, 2'd0);
    run_op("R7 neg max sub", 10'd11, 32'h000083FF, 2'd0);
    run_op("R5 widen inf", 10'd11, 32'h00007C00, 2'd0);
    run_op("R5 widen nan", 10'd11, 32'h0000FE01, 2'd0);
    run_op("R5 widen neg zero", 10'd11, 32'h00008000, 2'd0);
    run_op("R9 opcode 5", 10'd5, 32'h3F800000, 2'd0);
    run_op("R9 opcode 0", 10'd0, 32'hFFFFFFFF, 2'd0);

    held = result_o;
    run_op("R1 before idle", 10'd10, 32'h40490FDB, 2'd0);
    held = result_o;
    operand_i = 32'h12345678; opcode_i = 10'd11;
    repeat (3) @(negedge clk);
    chk("R10 idle valid", {31'h0, out_valid_o}, 32'h0);
    chk("R10 idle hold", result_o, held);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a; logic [1:0] rm;
      a  = $urandom();
      rm = 2'($urandom());
      if (i % 3 == 0) a[30:23] = 8'(8'd100 + 8'($urandom_range(0, 45)));
      run_op("R2 random narrow", 10'd10, a, rm);
    end
    for (int i = 0; i < 1500; i++) begin
      run_op("R6 random widen", 10'd11, $urandom(), 2'($urandom()));
    end
    for (int h = 0; h < 1024; h++) begin
      run_op("R7 all subnormals", 10'd11, 32'(h), 2'd0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule